// File: doc/BRIEF.md
# Timeout Watchdog Supervisor

This block watches a kick line from a host and drives an active-low fault output when the host stops kicking. After power-on reset, and again each time a fault pulse ends, it opens a startup-delay frame. That frame gives the host time to boot. A falling edge on the kick line ends the startup frame early and starts timeout monitoring. In the monitoring frame each kick falling edge restarts the count. If the count expires, the output is asserted for a programmed number of ticks, or held until a kick arrives when latched mode is selected.

All frame lengths are counted in ticks of a slow timebase. An external prescaler supplies the ticks as a one-cycle strobe. An enable line silently stops and restarts supervision. An active-low manual-reset line forces the output while it is held low. A frame-restart request lets a neighbouring period selector start a fresh timeout frame when the timeout value changes. The kick and manual-reset lines are asynchronous and pass through two-flop synchronisers.

Top module: `wdt_supervisor`

## Requirements
- R1: In the monitoring frame, a falling edge on the kick line restarts the count. Without such an edge, `fault_n` goes low on the tick that completes `timeout_ticks` ticks counted from frame entry. A zero period acts as one tick.
- R2: A watchdog fault keeps `fault_n` low for exactly `assert_ticks` ticks, with kicks ignored, and then releases it and opens a startup-delay frame.
- R3: A startup-delay frame starts after power-on reset and after every timed fault. During that frame `fault_n` stays high. If `startup_ticks` ticks pass with no kick, a fault is raised.
- R4: A kick falling edge during the startup-delay frame ends it at once and starts a full monitoring frame of `timeout_ticks` ticks.
- R5: When `startup_ticks` is zero, monitoring starts at once and no startup wait takes place.
- R6: While `wd_enable` is low, any frame or fault is dropped and `fault_n` stays high. Raising `wd_enable` starts a monitoring frame directly, with no startup-delay frame.
- R7: While the synchronised manual-reset line is low, `fault_n` is low, whatever `wd_enable` is. It is released as soon as the line returns high, with no stretch, and a startup-delay frame follows.
- R8: With `latch_mode` set (1), a watchdog fault holds `fault_n` low, through any number of ticks and restart requests, until a kick falling edge arrives. A manual-reset assertion in latched mode still releases when the line goes high.
- R9: A one-cycle `frame_restart` pulse during a startup or monitoring frame ends that frame and starts a fresh monitoring frame from zero.
- R10: A `frame_restart` pulse during a timed fault has no effect. The fault keeps its full length.
- R11: `fault_n` is registered and reads high after reset. A low level on `mrst_n_in` reaches `fault_n` on the third rising clock edge, and a return high is released on the third edge after it.
- R12: Frame counters advance only on cycles where `tick_en` is high. Any number of cycles without a tick never completes a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_en | input | 1 | One-cycle timebase strobe from the prescaler |
| kick_in | input | 1 | Asynchronous kick line; falling edges count as kicks |
| wd_enable | input | 1 | High enables supervision |
| mrst_n_in | input | 1 | Asynchronous active-low manual reset |
| frame_restart | input | 1 | One-cycle request to restart the frame after a period change |
| latch_mode | input | 1 | 1 selects a latched fault output |
| timeout_ticks | input | CW | Monitoring frame length in ticks |
| startup_ticks | input | CW | Startup-delay frame length in ticks, 0 for none |
| assert_ticks | input | CW | Timed fault length in ticks |
| fault_n | output | 1 | Registered active-low fault output |

## Verification
The bench drives the timebase strobe itself, so every frame length can be measured as an exact count of ticks. The core sweep covers every pairing of timeout length 1 to 4 with fault length 1 to 3. For each pairing it checks the output after every tick, which separates an off-by-one count in the monitoring frame from one in the fault stretch. Kicks are placed in four positions:
- partway through a monitoring frame, to show a restart against a plain expiry;
- inside the startup frame, to show that monitoring starts early and does not inherit the startup count;
- inside a fault, where the kick must be ignored;
- inside a latched fault, where the kick must release the output.

Further sequences with enable toggles, manual-reset pulses and restart requests each pick a period setting at which the wrong behaviour would change the output on a known tick.

// File: rtl/wdt_pkg.sv
// Shared types for the timeout watchdog supervisor.
// Assumes: one enum value per supervisor phase; encoding is free.
package wdt_pkg;
    typedef enum logic [2:0] {
        ST_DISABLED,
        ST_STARTUP,
        ST_MONITOR,
        ST_FAULT,
        ST_LATCHED,
        ST_MANUAL
    } wdt_state_e;
endpackage

// File: rtl/wdt_sync.sv
// Multi-stage synchroniser for an asynchronous level input.
// Assumes: the input changes slowly relative to clk; the output is reset to RESET_VAL.
module wdt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Each stage resamples the previous one (stage 0 takes the raw input).
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_fall_detect.sv
// Falling-edge detector on an already synchronised level.
// Assumes: the level idles high, so the history flop resets to 1.
module wdt_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_d;

    // Keep the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b1;
        else        lvl_d <= lvl;
    end

    assign fall = lvl_d & ~lvl;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R1
endmodule

// File: rtl/wdt_frame_counter.sv
// Tick counter for one frame; flags expiry on the tick that completes the period.
// Assumes: the owner clears it on every frame entry; period 0 behaves as 1.
module wdt_frame_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic          expire
);
    localparam int EW = CW + 1;

    logic [CW-1:0] cnt;
    logic [EW-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign expire  = tick && (cnt_inc >= {1'b0, period});

    // Count ticks within the current frame, starting again on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (tick && !expire)  cnt <= cnt_inc[CW-1:0];
    end

    AST_NO_TICK_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt)); // R12
endmodule

// File: rtl/wdt_supervisor.sv
// Timeout watchdog supervisor: startup-delay frame, monitoring frame,
// timed or latched fault, manual reset and silent disable.
// Assumes: tick_en is a one-cycle strobe; frame_restart is a one-cycle pulse
// from the period selector; kick_in and mrst_n_in are asynchronous.
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          kick_in,
    input  logic          wd_enable,
    input  logic          mrst_n_in,
    input  logic          frame_restart,
    input  logic          latch_mode,
    input  logic [CW-1:0] timeout_ticks,
    input  logic [CW-1:0] startup_ticks,
    input  logic [CW-1:0] assert_ticks,
    output logic          fault_n
);
    wdt_state_e    state, nxt;
    logic          kick_s, mr_s, kick_fall;
    logic          clr, expire;
    logic [CW-1:0] period;
    wdt_state_e    fault_target;

    wdt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_kick_sync (
        .clk(clk), .rst_n(rst_n), .d(kick_in), .q(kick_s));

    wdt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst_n(rst_n), .d(mrst_n_in), .q(mr_s));

    wdt_fall_detect u_kick_edge (
        .clk(clk), .rst_n(rst_n), .lvl(kick_s), .fall(kick_fall));

    wdt_frame_counter #(.CW(CW)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_en),
        .period(period), .expire(expire));

    // Pick the length of the frame that the current phase is timing.
    always_comb begin
        case (state)
            ST_STARTUP: period = startup_ticks;
            ST_FAULT:   period = assert_ticks;
            default:    period = timeout_ticks;
        endcase
    end

    assign fault_target = latch_mode ? ST_LATCHED : ST_FAULT;

    // Next phase and counter clear, highest-priority condition first.
    always_comb begin
        nxt = state;
        clr = 1'b1;
        if (!mr_s) begin
            nxt = ST_MANUAL;
        end else if (state == ST_MANUAL) begin
            nxt = wd_enable ? ST_STARTUP : ST_DISABLED;
        end else if (!wd_enable) begin
            nxt = ST_DISABLED;
        end else if (state == ST_DISABLED) begin
            nxt = ST_MONITOR;
        end else if (frame_restart && (state == ST_STARTUP || state == ST_MONITOR)) begin
            nxt = ST_MONITOR;
        end else begin
            case (state)
                ST_STARTUP: begin
                    if (startup_ticks == '0 || kick_fall) nxt = ST_MONITOR;
                    else if (expire)                      nxt = fault_target;
                    else                                  clr = 1'b0;
                end
                ST_MONITOR: begin
                    if (kick_fall)   nxt = ST_MONITOR;
                    else if (expire) nxt = fault_target;
                    else             clr = 1'b0;
                end
                ST_FAULT: begin
                    if (expire) nxt = ST_STARTUP;
                    else        clr = 1'b0;
                end
                ST_LATCHED: begin
                    if (kick_fall) nxt = ST_STARTUP;
                    else           clr = 1'b0;
                end
                default: nxt = ST_DISABLED;
            endcase
        end
    end

    // Phase register; power-on reset opens the startup-delay frame.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STARTUP;
        else        state <= nxt;
    end

    // Registered active-low output, low in every asserting phase.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n <= 1'b1;
        else        fault_n <= !(nxt == ST_FAULT || nxt == ST_LATCHED || nxt == ST_MANUAL);
    end

    AST_MR_FORCES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_s |=> !fault_n); // R7
    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_s && !wd_enable) |=> fault_n); // R6
    AST_STARTUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STARTUP && mr_s && wd_enable && !expire) |=> fault_n); // R3
    AST_KICK_KEEPS_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MONITOR && kick_fall && mr_s && wd_enable)
        |=> (state == ST_MONITOR && fault_n)); // R1
    AST_FAULT_ENDS_IN_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && expire && mr_s && wd_enable)
        |=> (state == ST_STARTUP && fault_n)); // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && mr_s && wd_enable && !kick_fall) |=> !fault_n); // R8
    AST_RESTART_IGNORED_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && frame_restart && mr_s && wd_enable && !expire)
        |=> (state == ST_FAULT)); // R10
endmodule

// File: tb/wdt_supervisor_bench.sv
// Self-checking bench: drives the tick strobe directly and counts frames in ticks.
module wdt_supervisor_bench;
    localparam int CW    = 8;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          kick_in = 1'b1;
    logic          wd_enable = 1'b1;
    logic          mrst_n_in = 1'b1;
    logic          frame_restart = 1'b0;
    logic          latch_mode = 1'b0;
    logic [CW-1:0] timeout_ticks = 8'd3;
    logic [CW-1:0] startup_ticks = 8'd2;
    logic [CW-1:0] assert_ticks = 8'd2;
    logic          fault_n;

    int n_vec = 0;
    int n_bad = 0;

    wdt_supervisor #(.CW(CW)) u_wdt_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick_in(kick_in),
        .wd_enable(wd_enable), .mrst_n_in(mrst_n_in), .frame_restart(frame_restart),
        .latch_mode(latch_mode), .timeout_ticks(timeout_ticks),
        .startup_ticks(startup_ticks), .assert_ticks(assert_ticks), .fault_n(fault_n));

    always #5 clk = ~clk;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        idle(1);
    endtask

    task automatic kick();
        kick_in = 1'b0;
        idle(5);
        kick_in = 1'b1;
        idle(5);
    endtask

    task automatic restart_pulse();
        frame_restart = 1'b1;
        @(negedge clk);
        frame_restart = 1'b0;
        idle(2);
    endtask

    task automatic chk(input logic exp, input string tag);
        n_vec++;
        if (fault_n !== exp) begin
            n_bad++;
            $display("FAIL %s: fault_n got %0b expected %0b", tag, fault_n, exp);
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        chk(1'b1, "R11 reset state");
        idle(50);
        chk(1'b1, "R12 no tick no expiry");
        // Startup frame after reset: 2 ticks with no kick raise a fault.
        tick(); chk(1'b1, "R3 startup silent");
        tick(); chk(1'b0, "R3 startup expiry");
        tick(); chk(1'b0, "R2 fault held");
        tick(); chk(1'b1, "R2 fault released");
        // New startup frame; one tick spent, then a kick opens monitoring.
        tick(); chk(1'b1, "R3 startup after fault");
        kick();
        tick(); chk(1'b1, "R4 monitor after kick");
        tick(); chk(1'b1, "R4 monitor full length");
        tick(); chk(1'b0, "R4 monitor expiry");
        tick(); tick(); chk(1'b1, "R2 release");

        // Sweep timeout and fault lengths.
        for (int t = 1; t <= 4; t++) begin
            for (int a = 1; a <= 3; a++) begin
                timeout_ticks = CW'(t);
                assert_ticks  = CW'(a);
                kick();
                for (int k = 1; k <= t; k++) begin
                    tick();
                    chk((k < t) ? 1'b1 : 1'b0, "R1 timeout count");
                end
                for (int j = 1; j <= a; j++) begin
                    if (j == 1) begin
                        kick();
                        chk(1'b0, "R2 kick ignored in fault");
                    end
                    tick();
                    chk((j == a) ? 1'b1 : 1'b0, "R2 fault length");
                end
            end
        end

        // A kick in mid-frame restarts monitoring.
        timeout_ticks = 8'd3; assert_ticks = 8'd2;
        kick();
        tick(); tick();
        kick();
        tick(); tick(); chk(1'b1, "R1 kick restarts frame");
        tick(); chk(1'b0, "R1 expiry after restart");
        tick(); tick(); chk(1'b1, "R2 release");

        // Zero startup delay: monitoring begins without waiting.
        startup_ticks = 8'd0; timeout_ticks = 8'd4;
        idle(3);
        tick(); tick(); tick(); chk(1'b1, "R5 zero startup monitor");
        tick(); chk(1'b0, "R5 zero startup expiry");
        startup_ticks = 8'd2; timeout_ticks = 8'd3;
        tick(); tick(); chk(1'b1, "R2 release");

        // Restart request in monitoring, then ignored during a fault.
        kick();
        tick(); tick();
        restart_pulse();
        tick(); tick(); chk(1'b1, "R9 restart in monitor");
        tick(); chk(1'b0, "R9 expiry after restart");
        tick();
        restart_pulse(); chk(1'b0, "R10 restart ignored in fault");
        tick(); chk(1'b1, "R10 fault full length");
        // Restart request during the startup frame.
        tick();
        restart_pulse();
        tick(); chk(1'b1, "R9 restart in startup");
        tick(); chk(1'b1, "R9 restart in startup");
        tick(); chk(1'b0, "R9 monitor expiry");
        tick(); tick(); chk(1'b1, "R2 release");

        // Enable off drops supervision; enable on skips startup.
        kick();
        wd_enable = 1'b0;
        idle(2);
        for (int i = 0; i < 10; i++) tick();
        chk(1'b1, "R6 disabled quiet");
        startup_ticks = 8'd5; timeout_ticks = 8'd2;
        wd_enable = 1'b1;
        idle(2);
        tick(); chk(1'b1, "R6 reenable monitor");
        tick(); chk(1'b0, "R6 reenable no startup");
        wd_enable = 1'b0;
        idle(2); chk(1'b1, "R6 disable releases fault");
        wd_enable = 1'b1;
        idle(2);
        timeout_ticks = 8'd3; startup_ticks = 8'd2;
        kick();

        // Manual reset latency, hold and release.
        mrst_n_in = 1'b0;
        idle(2); chk(1'b1, "R11 mr latency before");
        idle(1); chk(1'b0, "R11 mr latency at");
        for (int i = 0; i < 10; i++) tick();
        chk(1'b0, "R7 mr held");
        wd_enable = 1'b0;
        idle(2); chk(1'b0, "R7 mr over enable");
        wd_enable = 1'b1;
        mrst_n_in = 1'b1;
        idle(2); chk(1'b0, "R11 release latency before");
        idle(1); chk(1'b1, "R7 release no stretch");
        tick(); chk(1'b1, "R7 startup after release");
        tick(); chk(1'b0, "R7 startup expiry");
        tick(); tick(); chk(1'b1, "R2 release");

        // Latched mode.
        latch_mode = 1'b1;
        kick();
        tick(); tick(); tick(); chk(1'b0, "R8 latched fault");
        for (int i = 0; i < 8; i++) tick();
        chk(1'b0, "R8 latched held");
        restart_pulse(); chk(1'b0, "R8 latched restart");
        kick(); chk(1'b1, "R8 kick releases");
        mrst_n_in = 1'b0;
        idle(5); chk(1'b0, "R8 mr in latched");
        mrst_n_in = 1'b1;
        idle(5); chk(1'b1, "R8 mr release in latched");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule